// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block conditions four external interrupt pins before they reach a downstream priority encoder. Each pin is first synchronized to the core clock. It is then judged as a level or an edge condition, according to a two-bit sense code that is set per line. Edge events are held in a sticky flag until software acknowledges them. Each line is gated by its own enable bit, and the result is driven onto a per-line request output.

All configuration sits in one 32-bit control register on a single-register bus. Software updates one field by reading the register, changing that field and writing the word back. For that reason, every bit the block does not act on reads back exactly as it was written. The acknowledge bits are write-one-to-clear strobes and always read as zero.

Top module: `extint_sense_ctrl`

## Requirements
- R1: After reset the control register reads 0 and all request outputs are 0.
- R2: A write stores every bit except 27:24. Those four bits always read as 0. Without a write, the read value does not change.
- R3: With sense code 0 (level high) on line n, reqOut[n] equals the pin value delayed by two clock edges, gated by the enable bit.
- R4: With sense code 3 (level low) on line n, reqOut[n] equals the inverted pin value delayed by two clock edges, gated by the enable bit.
- R5: With sense code 1 (rising edge), a 0-to-1 pin transition latches an event. The event shows on reqOut[n] three edges after the pin change and stays there after the pin falls again.
- R6: With sense code 2 (falling edge), only a 1-to-0 transition latches an event, with the same latency. A rising transition has no effect in this mode.
- R7: Writing 1 to bit 27-n clears the latched event of line n at that write edge. Ack bits of other lines, and ack bits written as 0, leave the event in place.
- R8: Enable bit 11-n set to 0 forces reqOut[n] to 0. A latched event is kept while the line is masked and appears as soon as the line is enabled again.
- R9: If an edge is detected in the same cycle as an acknowledge of that line, the new event is kept.
- R10: The sense code of line n sits at bits [23-2n:22-2n]. For example, line 2 uses bits 19:18, and line 0 uses bits 23:22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access select |
| busWrite | input | 1 | Write strobe; valid while busSel is high |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Control register read value (ack bits read 0) |
| pinIn | input | 4 | Asynchronous external interrupt pins |
| reqOut | output | 4 | Per-line conditioned request to the priority encoder |

## Verification
A pin change reaches a level-mode request after two rising edges, and an edge-mode request after three, because of the two synchronizer flops and the event latch. Register writes, acknowledges and enable changes take effect at the edge that accepts the write. The bench drives inputs on the falling edge and samples one falling edge after each counted rising edge. Its directed cases check one edge early as well, which catches a missing or extra stage. The random phase runs a cycle-accurate reference model, built from the requirements, in step with the design and compares against it at every falling edge.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam int NUM_LINES = 4;

  typedef enum logic [1:0] {
    SENSE_HIGH = 2'd0,
    SENSE_RISE = 2'd1,
    SENSE_FALL = 2'd2,
    SENSE_LOW  = 2'd3
  } senseT;

  // Per-line strobes and settings passed from control to datapath
  typedef struct packed {
    senseT sense;
    logic  enable;
    logic  ackClr;
  } lineCfgT;

endpackage

// File: rtl/extint_ctrl_regs.sv
module extint_ctrl_regs
  import extint_pkg::*;
#(
  parameter int REG_WIDTH = 32,
  parameter int ENA_TOP   = 11,
  parameter int ACK_TOP   = 27,
  parameter int SENSE_TOP = 23
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            busSel,
  input  logic                            busWrite,
  input  logic [REG_WIDTH-1:0]            busWdata,
  output logic [REG_WIDTH-1:0]            busRdata,
  output lineCfgT [NUM_LINES-1:0]         lineCfg
);

  localparam int ACK_LOW = ACK_TOP - NUM_LINES + 1;

  function automatic logic [REG_WIDTH-1:0] ackMaskFn();
    logic [REG_WIDTH-1:0] m;
    m = '0;
    for (int i = ACK_LOW; i <= ACK_TOP; i++) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_WIDTH-1:0] ACK_MASK = ackMaskFn();

  logic [REG_WIDTH-1:0] ctrlQ;
  logic                 writeHit;

  assign writeHit = busSel & busWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (writeHit) begin
      ctrlQ <= busWdata & ~ACK_MASK;
    end
  end

  assign busRdata = ctrlQ;

  for (genvar n = 0; n < NUM_LINES; n++) begin : gLineCfg
    localparam int SLO = SENSE_TOP - 1 - 2 * n;
    assign lineCfg[n].sense  = senseT'(ctrlQ[SLO +: 2]);
    assign lineCfg[n].enable = ctrlQ[ENA_TOP - n];
    assign lineCfg[n].ackClr = writeHit & busWdata[ACK_TOP - n];
  end

endmodule

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinAsync,
  output logic syncOut,
  output logic prevOut
);

  logic [STAGES:0] chainQ;

  always_ff @(posedge clk) begin
    if (!rstN) chainQ <= '0;
    else       chainQ <= {chainQ[STAGES-1:0], pinAsync};
  end

  assign syncOut = chainQ[STAGES-1];
  assign prevOut = chainQ[STAGES];

endmodule

// File: rtl/extint_line.sv
module extint_line
  import extint_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  lineCfgT cfg,
  input  logic    syncIn,
  input  logic    prevIn,
  output logic    req
);

  logic riseSeen;
  logic fallSeen;
  logic eventHit;
  logic latchQ;
  logic rawReq;

  assign riseSeen = syncIn & ~prevIn;
  assign fallSeen = ~syncIn & prevIn;
  assign eventHit = ((cfg.sense == SENSE_RISE) & riseSeen) |
                    ((cfg.sense == SENSE_FALL) & fallSeen);

  // A fresh event outranks a simultaneous acknowledge
  always_ff @(posedge clk) begin
    if (!rstN)            latchQ <= 1'b0;
    else if (eventHit)    latchQ <= 1'b1;
    else if (cfg.ackClr)  latchQ <= 1'b0;
  end

  always_comb begin
    unique case (cfg.sense)
      SENSE_HIGH: rawReq = syncIn;
      SENSE_LOW:  rawReq = ~syncIn;
      default:    rawReq = latchQ;
    endcase
  end

  assign req = cfg.enable & rawReq;

endmodule

// File: rtl/extint_sense_ctrl.sv
module extint_sense_ctrl
  import extint_pkg::*;
#(
  parameter int REG_WIDTH   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [REG_WIDTH-1:0] busWdata,
  output logic [REG_WIDTH-1:0] busRdata,
  input  logic [3:0]           pinIn,
  output logic [3:0]           reqOut
);

  lineCfgT [NUM_LINES-1:0] lineCfg;
  logic    [NUM_LINES-1:0] syncVal;
  logic    [NUM_LINES-1:0] prevVal;

  extint_ctrl_regs #(.REG_WIDTH(REG_WIDTH)) uRegs (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .lineCfg  (lineCfg)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : gLine
    extint_sync #(.STAGES(SYNC_STAGES)) uSync (
      .clk      (clk),
      .rstN     (rstN),
      .pinAsync (pinIn[n]),
      .syncOut  (syncVal[n]),
      .prevOut  (prevVal[n])
    );

    extint_line uLine (
      .clk    (clk),
      .rstN   (rstN),
      .cfg    (lineCfg[n]),
      .syncIn (syncVal[n]),
      .prevIn (prevVal[n]),
      .req    (reqOut[n])
    );
  end

endmodule

// File: rtl/extint_sense_ctrl_chk.sv
module extint_sense_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busSel,
  input logic        busWrite,
  input logic [31:0] busWdata,
  input logic [31:0] busRdata,
  input logic [3:0]  pinIn,
  input logic [3:0]  reqOut
);

  AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[27:24] == 4'h0); // R2

  AST_WRITE_STORED: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite) |=> (busRdata == ($past(busWdata) & 32'hF0FF_FFFF))); // R2

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWrite) |=> $stable(busRdata)); // R2

  for (genvar n = 0; n < 4; n++) begin : gPer
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      !busRdata[11-n] |-> !reqOut[n]); // R8

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (reqOut[n] && (busRdata[23-2*n -: 2] inside {2'd1, 2'd2}) && !(busSel && busWrite))
      |=> reqOut[n]); // R5
  end

endmodule

bind extint_sense_ctrl extint_sense_ctrl_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .pinIn    (pinIn),
  .reqOut   (reqOut)
);

// File: tb/extint_sense_ctrl_test.sv
`timescale 1ns/1ps
module extint_sense_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  pinIn = '0;
  logic [3:0]  reqOut;

  int nChecks = 0;
  int nErrors = 0;

  always #2.5 clk = ~clk;

  extint_sense_ctrl uut (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .pinIn    (pinIn),
    .reqOut   (reqOut)
  );

  // Reference model written from the requirements
  logic [31:0] mReg;
  logic [3:0]  m1, m2, m3, mLat;

  always @(posedge clk) begin
    if (!rstN) begin
      mReg <= '0; m1 <= '0; m2 <= '0; m3 <= '0; mLat <= '0;
    end else begin
      m1 <= pinIn;
      m2 <= m1;
      m3 <= m2;
      for (int n = 0; n < 4; n++) begin
        logic [1:0] sn;
        logic evt;
        sn  = mReg[23-2*n -: 2];
        evt = (sn == 2'd1 && m2[n] && !m3[n]) || (sn == 2'd2 && !m2[n] && m3[n]);
        if (evt) mLat[n] <= 1'b1;
        else if (busSel && busWrite && busWdata[27-n]) mLat[n] <= 1'b0;
      end
      if (busSel && busWrite) mReg <= busWdata & 32'hF0FF_FFFF;
    end
  end

  function automatic logic [3:0] expReq();
    logic [3:0] r;
    for (int n = 0; n < 4; n++) begin
      logic [1:0] sn;
      sn = mReg[23-2*n -: 2];
      case (sn)
        2'd0:    r[n] = m2[n];
        2'd3:    r[n] = !m2[n];
        default: r[n] = mLat[n];
      endcase
      r[n] = r[n] & mReg[11-n];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic setPins(input logic [3:0] v);
    @(negedge clk);
    pinIn = v;
  endtask

  task automatic waitEdges(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic chkReq(input string req, input logic [3:0] exp);
    check(reqOut === exp, req, {28'h0, reqOut}, {28'h0, exp});
  endtask

  initial begin
    #500000;
    nChecks++;
    nErrors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    waitEdges(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busRdata === 32'h0, "R1 reg", busRdata, 32'h0);
    chkReq("R1 req", 4'h0);

    // R2 readback
    busWr(32'hFFFF_FFFF);
    check(busRdata === 32'hF0FF_FFFF, "R2 ones", busRdata, 32'hF0FF_FFFF);
    busWr(32'hA5A5_A5A5);
    check(busRdata === 32'hA0A5_A5A5, "R2 pattern", busRdata, 32'hA0A5_A5A5);
    waitEdges(2);
    check(busRdata === 32'hA0A5_A5A5, "R2 hold", busRdata, 32'hA0A5_A5A5);

    // R3 level high, all lines enabled
    busWr(32'h0000_0F00);
    waitEdges(3);
    setPins(4'b0101);
    waitEdges(1);
    chkReq("R3 early", 4'b0000);
    waitEdges(1);
    chkReq("R3 level", 4'b0101);

    // R4 level low
    busWr(32'h00FF_0F00);
    waitEdges(1);
    chkReq("R4 level", 4'b1010);
    setPins(4'b0000);
    waitEdges(3);

    // R5 / R10: line 2 rising, sense at bits 19:18, enable bit 9
    busWr(32'h0004_0200);
    setPins(4'b0100);
    waitEdges(2);
    chkReq("R5 early", 4'b0000);
    waitEdges(1);
    chkReq("R5 R10 rise", 4'b0100);
    setPins(4'b0000);
    waitEdges(4);
    chkReq("R5 sticky", 4'b0100);

    // R7 acknowledge
    busWr(32'h0D04_0200);
    chkReq("R7 other ack", 4'b0100);
    check(busRdata === 32'h0004_0200, "R2 ack reads 0", busRdata, 32'h0004_0200);
    busWr(32'h0204_0200);
    chkReq("R7 own ack", 4'b0000);

    // R8 masking keeps the event
    busWr(32'h0004_0000);
    setPins(4'b0100);
    waitEdges(4);
    chkReq("R8 masked", 4'b0000);
    setPins(4'b0000);
    waitEdges(2);
    busWr(32'h0004_0200);
    chkReq("R8 unmask", 4'b0100);
    busWr(32'h0204_0200);
    chkReq("R7 clear", 4'b0000);

    // R6 line 0 falling, sense bits 23:22, enable bit 11
    busWr(32'h0080_0800);
    setPins(4'b0001);
    waitEdges(4);
    chkReq("R6 rise ignored", 4'b0000);
    setPins(4'b0000);
    waitEdges(2);
    chkReq("R6 early", 4'b0000);
    waitEdges(1);
    chkReq("R6 fall", 4'b0001);
    busWr(32'h0880_0800);
    chkReq("R7 clear line0", 4'b0000);

    // R9 edge and ack in the same cycle
    busWr(32'h0010_0400);
    setPins(4'b0010);
    @(negedge clk);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busWdata = 32'h0410_0400;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
    chkReq("R9 event kept", 4'b0010);
    busWr(32'h0410_0400);
    chkReq("R9 later ack", 4'b0000);

    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      check(reqOut === expReq(), "R3 R4 R5 R6 R7 R8 model", {28'h0, reqOut}, {28'h0, expReq()});
      check(busRdata === mReg, "R2 model", busRdata, mReg);
      if (($urandom % 4) == 0) pinIn = 4'($urandom);
      if (($urandom % 6) == 0) begin
        busSel = 1'b1; busWrite = 1'b1; busWdata = $urandom;
      end else begin
        busSel = ($urandom % 2) == 0; busWrite = 1'b0; busWdata = $urandom;
      end
    end
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule